// File: doc/BRIEF.md
# Coprocessor Instruction Class Decoder

This block looks at the first two 16-bit words of a floating-point coprocessor instruction and sorts the instruction into one operation class. First it checks the opcode header: the coprocessor escape nibble and the coprocessor identity. Then it reads a three-bit type field in the first word. For the general type, a second, prioritised set of bit-pattern tests on the second word picks out the special operations. Whatever matches none of those tests counts as arithmetic.

For arithmetic instructions the decoder also splits the second word into its fields:

- the memory-source flag,
- the source format,
- the destination register,
- the operation code.

When the source is in memory, it also reports the operand size in bytes. For every instruction it reports the length in bytes that the class and the first word imply. Addressing-mode decoding, operand fetch and execution are left to later stages.

A front end presents both words with a one-cycle strobe. The classification appears one clock later with a one-cycle valid pulse. It stays on the outputs until the next strobe.

Top module: `cop_class_decoder`

## Requirements
- R1: When `inValid` is high at a rising clock edge, all outputs are loaded from that cycle's words and `outValid` is high for exactly the following cycle. Without a strobe `outValid` is low and every other output holds its value.
- R2: A first word whose bits 15:12 are not 1111 is classified illegal.
- R3: A first word whose bits 11:9 differ from parameter `COP_ID` (default 1) is classified illegal.
- R4: Type field = first-word bits 8:6.
  - Type 2 is a branch of length 4.
  - Type 3 is a branch of length 6.
  - Types 4 to 7 are illegal.
- R5: For type 0, the second word is tested in this priority order:
  1. Bits 15:14 = 11 gives a register-multiple move.
  2. Bits 15:14 = 10 gives a control-register move.
  3. Bits 15:13 = 011 gives a store.
  4. Bits 15:10 = 010111 gives a constant load.
  5. (word1 AND 0xA07F) = 0x0026 gives scale.
  6. Anything else is arithmetic.

  All type-0 classes have length 4.
- R6: For arithmetic, `srcMem` = word1[14], `srcFmt` = word1[12:10], `dstReg` = word1[9:7] and `opCode` = word1[6:0]. For every other class these four outputs are zero.
- R7: For arithmetic with `srcMem` = 1, `srcBytes` comes from the format code:
  - 0 gives 4
  - 1 gives 4
  - 2 gives 12
  - 4 gives 2
  - 5 gives 8
  - 6 gives 1

  Codes 3 and 7 give `srcBytes` = 0 and `fmtErr` = 1. With a register source, or a class other than arithmetic, `srcBytes` and `fmtErr` are 0.
- R8: Type 1 is the conditional class, sorted by first-word bits 5:3 and 2:0:
  - Bits 5:3 = 001 is decrement-and-branch (`condKind` 2), length 6.
  - Bits 5:3 = 111 with bits 2:0 = 2, 3 or 4 is a trap (`condKind` 3), length 6, 8 or 4.
  - Bits 5:3 = 111 with bits 2:0 = 5, 6 or 7 is illegal.
  - Every other combination is set-on-condition (`condKind` 1), length 4.

  `condKind` is 0 for all other classes.
- R9: `classHot` has exactly one bit set on every valid result. Bit order:
  - 0 register-multiple
  - 1 control move
  - 2 store
  - 3 constant load
  - 4 scale
  - 5 arithmetic
  - 6 branch
  - 7 conditional
  - 8 illegal

  `illegal` equals bit 8, and an illegal result reports `lenBytes` = 0.
- R10: An asynchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Strobe: decode this cycle's words |
| word0 | input | 16 | First instruction word (opcode) |
| word1 | input | 16 | Second instruction word (command) |
| outValid | output | 1 | One-cycle pulse marking a new result |
| classHot | output | 9 | One-hot operation class |
| illegal | output | 1 | Instruction is illegal |
| condKind | output | 2 | Conditional sub-kind: 0 none, 1 set, 2 decrement-branch, 3 trap |
| lenBytes | output | LEN_W | Instruction length in bytes (0 if illegal) |
| srcMem | output | 1 | Arithmetic source is in memory |
| srcFmt | output | 3 | Arithmetic source format or source register |
| dstReg | output | 3 | Arithmetic destination register |
| opCode | output | 7 | Arithmetic operation code |
| srcBytes | output | 4 | Memory operand size in bytes |
| fmtErr | output | 1 | Memory source format is unsupported |

## Verification
The bench builds the decoder with `COP_ID` = 1 and `LEN_W` = 4. The identity value of 1 makes the escape-nibble and identity checks reachable with ordinary opcodes, and any other identity value in bits 11:9 exercises the mismatch path. Four length bits hold the longest result of 8 bytes, reached by a trap with a long operand, without truncation. Under that build every format code, every trap operand mode and each adjacent pair in the type-0 priority chain can be exercised, including the overlaps where a constant-load pattern also matches the scale mask.

// File: rtl/cop_dec_pkg.sv
package cop_dec_pkg;

  localparam int NCLASS  = 9;
  localparam int SIZE_W  = 4;

  localparam int C_MULTI  = 0;
  localparam int C_CTRL   = 1;
  localparam int C_STORE  = 2;
  localparam int C_CONST  = 3;
  localparam int C_SCALE  = 4;
  localparam int C_ARITH  = 5;
  localparam int C_BRANCH = 6;
  localparam int C_COND   = 7;
  localparam int C_ILL    = 8;

  typedef enum logic [1:0] {
    CK_NONE = 2'd0,
    CK_SET  = 2'd1,
    CK_DBR  = 2'd2,
    CK_TRAP = 2'd3
  } condKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic [NCLASS-1:0] classHot;
    condKind_e         condKind;
    logic [1:0]        extraWords;   // extension words beyond the base 4 bytes
  } ctlStrobe_t;

  // Memory operand size per source format code; 0 marks an unsupported code
  function automatic logic [SIZE_W-1:0] fmtBytes(input logic [2:0] fmt);
    case (fmt)
      3'd0:    fmtBytes = SIZE_W'(4);
      3'd1:    fmtBytes = SIZE_W'(4);
      3'd2:    fmtBytes = SIZE_W'(12);
      3'd4:    fmtBytes = SIZE_W'(2);
      3'd5:    fmtBytes = SIZE_W'(8);
      3'd6:    fmtBytes = SIZE_W'(1);
      default: fmtBytes = '0;
    endcase
  endfunction

endpackage

// File: rtl/cop_dec_ctrl.sv
module cop_dec_ctrl
  import cop_dec_pkg::*;
#(
  parameter logic [2:0] COP_ID = 3'd1
) (
  input  logic        inValid,
  input  logic [15:0] word0,
  input  logic [5:0]  w1Hi,    // word1[15:10]
  input  logic [6:0]  w1Op,    // word1[6:0]
  output ctlStrobe_t  ctl
);

  logic [3:0] opType;
  logic       headOk;
  logic [2:0] condSel;
  logic [2:0] oprMode;
  int         cls;

  assign opType  = {1'b0, word0[8:6]};
  assign headOk  = (word0[15:12] == 4'hF) && (word0[11:9] == COP_ID);
  assign condSel = word0[5:3];
  assign oprMode = word0[2:0];

  always_comb begin
    cls                = C_ILL;
    ctl.load           = inValid;
    ctl.condKind       = CK_NONE;
    ctl.extraWords     = 2'd0;
    if (headOk) begin
      case (opType)
        4'd0: begin
          if (w1Hi[5:4] == 2'b11)                              cls = C_MULTI;
          else if (w1Hi[5:4] == 2'b10)                         cls = C_CTRL;
          else if (w1Hi[5:3] == 3'b011)                        cls = C_STORE;
          else if (w1Hi == 6'b010111)                          cls = C_CONST;
          else if (!w1Hi[5] && !w1Hi[3] && w1Op == 7'h26)      cls = C_SCALE;
          else                                                 cls = C_ARITH;
        end
        4'd1: begin
          cls = C_COND;
          if (condSel == 3'b001) begin
            ctl.condKind   = CK_DBR;
            ctl.extraWords = 2'd1;
          end else if (condSel == 3'b111 && oprMode >= 3'd2) begin
            case (oprMode)
              3'd2: begin ctl.condKind = CK_TRAP; ctl.extraWords = 2'd1; end
              3'd3: begin ctl.condKind = CK_TRAP; ctl.extraWords = 2'd2; end
              3'd4: begin ctl.condKind = CK_TRAP; ctl.extraWords = 2'd0; end
              default: cls = C_ILL;
            endcase
          end else begin
            ctl.condKind = CK_SET;
          end
        end
        4'd2: cls = C_BRANCH;
        4'd3: begin cls = C_BRANCH; ctl.extraWords = 2'd1; end
        default: cls = C_ILL;
      endcase
    end
    ctl.classHot      = '0;
    ctl.classHot[cls] = 1'b1;
  end

endmodule

// File: rtl/cop_dec_dp.sv
module cop_dec_dp
  import cop_dec_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        ctl,
  input  logic              w1Mem,    // word1[14]
  input  logic [12:0]       w1Low,    // word1[12:0]
  output logic              outValid,
  output logic [NCLASS-1:0] classHot,
  output logic              illegal,
  output logic [1:0]        condKind,
  output logic [LEN_W-1:0]  lenBytes,
  output logic              srcMem,
  output logic [2:0]        srcFmt,
  output logic [2:0]        dstReg,
  output logic [6:0]        opCode,
  output logic [SIZE_W-1:0] srcBytes,
  output logic              fmtErr
);

  logic              isArith;
  logic              memSrc;
  logic [SIZE_W-1:0] sizeNext;
  logic [LEN_W-1:0]  lenNext;

  assign isArith  = ctl.classHot[C_ARITH];
  assign memSrc   = isArith && w1Mem;
  assign sizeNext = memSrc ? fmtBytes(w1Low[12:10]) : '0;
  assign lenNext  = ctl.classHot[C_ILL] ? '0
                  : LEN_W'(32'd4 + 32'(ctl.extraWords) * 32'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      classHot <= '0;
      illegal  <= 1'b0;
      condKind <= 2'd0;
      lenBytes <= '0;
      srcMem   <= 1'b0;
      srcFmt   <= 3'd0;
      dstReg   <= 3'd0;
      opCode   <= 7'd0;
      srcBytes <= '0;
      fmtErr   <= 1'b0;
    end else begin
      outValid <= ctl.load;
      if (ctl.load) begin
        classHot <= ctl.classHot;
        illegal  <= ctl.classHot[C_ILL];
        condKind <= ctl.condKind;
        lenBytes <= lenNext;
        srcMem   <= memSrc;
        srcFmt   <= isArith ? w1Low[12:10] : 3'd0;
        dstReg   <= isArith ? w1Low[9:7]   : 3'd0;
        opCode   <= isArith ? w1Low[6:0]   : 7'd0;
        srcBytes <= sizeNext;
        fmtErr   <= memSrc && (sizeNext == '0);
      end
    end
  end

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> $stable(classHot) && $stable(lenBytes) && $stable(opCode)); // R1
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $countones(classHot) == 1); // R9
  AST_ILLEGAL_NO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && illegal |-> lenBytes == '0); // R9
  AST_FMT_ERR_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && fmtErr |-> classHot[C_ARITH] && srcMem && srcBytes == '0); // R7
  AST_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !classHot[C_ARITH] |-> opCode == 7'd0 && dstReg == 3'd0 && !srcMem); // R6

endmodule

// File: rtl/cop_class_decoder.sv
module cop_class_decoder
  import cop_dec_pkg::*;
#(
  parameter logic [2:0] COP_ID = 3'd1,
  parameter int         LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [15:0]       word0,
  input  logic [15:0]       word1,
  output logic              outValid,
  output logic [8:0]        classHot,
  output logic              illegal,
  output logic [1:0]        condKind,
  output logic [LEN_W-1:0]  lenBytes,
  output logic              srcMem,
  output logic [2:0]        srcFmt,
  output logic [2:0]        dstReg,
  output logic [6:0]        opCode,
  output logic [3:0]        srcBytes,
  output logic              fmtErr
);

  ctlStrobe_t ctl;

  cop_dec_ctrl #(.COP_ID(COP_ID)) u_ctrl (
    .inValid (inValid),
    .word0   (word0),
    .w1Hi    (word1[15:10]),
    .w1Op    (word1[6:0]),
    .ctl     (ctl)
  );

  cop_dec_dp #(.LEN_W(LEN_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .w1Mem    (word1[14]),
    .w1Low    (word1[12:0]),
    .outValid (outValid),
    .classHot (classHot),
    .illegal  (illegal),
    .condKind (condKind),
    .lenBytes (lenBytes),
    .srcMem   (srcMem),
    .srcFmt   (srcFmt),
    .dstReg   (dstReg),
    .opCode   (opCode),
    .srcBytes (srcBytes),
    .fmtErr   (fmtErr)
  );

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid); // R1
  AST_BAD_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && word0[15:12] != 4'hF |=> illegal); // R2
  AST_BAD_ID: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && word0[11:9] != COP_ID |=> illegal); // R3
  AST_PRIV_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && word0[8] |=> illegal && lenBytes == '0); // R4
  AST_LONG_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && word0[15:12] == 4'hF && word0[11:9] == COP_ID && word0[8:6] == 3'd3
    |=> classHot[C_BRANCH] && lenBytes == LEN_W'(6)); // R4

endmodule

// File: tb/tb_cop_class_decoder.sv
module tb_cop_class_decoder;

  localparam int LEN_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              inValid = 1'b0;
  logic [15:0]       word0 = '0;
  logic [15:0]       word1 = '0;
  logic              outValid;
  logic [8:0]        classHot;
  logic              illegal;
  logic [1:0]        condKind;
  logic [LEN_W-1:0]  lenBytes;
  logic              srcMem;
  logic [2:0]        srcFmt;
  logic [2:0]        dstReg;
  logic [6:0]        opCode;
  logic [3:0]        srcBytes;
  logic              fmtErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  cop_class_decoder #(.COP_ID(3'd1), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .word0(word0), .word1(word1),
    .outValid(outValid), .classHot(classHot), .illegal(illegal),
    .condKind(condKind), .lenBytes(lenBytes), .srcMem(srcMem),
    .srcFmt(srcFmt), .dstReg(dstReg), .opCode(opCode),
    .srcBytes(srcBytes), .fmtErr(fmtErr)
  );

  typedef struct packed {
    logic [15:0] w0;
    logic [15:0] w1;
    logic [3:0]  cls;
    logic [3:0]  len;
    logic [1:0]  ck;
    logic [3:0]  sz;
    logic        fe;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{16'hF200, 16'hC0FF, 4'd0, 4'd4, 2'd0, 4'd0,  1'b0, 4'd5}, // R5 reg-multiple
    '{16'hF200, 16'h9C00, 4'd1, 4'd4, 2'd0, 4'd0,  1'b0, 4'd5}, // R5 control move
    '{16'hF200, 16'h6000, 4'd2, 4'd4, 2'd0, 4'd0,  1'b0, 4'd5}, // R5 store
    '{16'hF200, 16'h5C05, 4'd3, 4'd4, 2'd0, 4'd0,  1'b0, 4'd5}, // R5 constant load
    '{16'hF200, 16'h5C26, 4'd3, 4'd4, 2'd0, 4'd0,  1'b0, 4'd5}, // R5 const beats scale
    '{16'hF200, 16'h0026, 4'd4, 4'd4, 2'd0, 4'd0,  1'b0, 4'd5}, // R5 scale
    '{16'hF200, 16'h4426, 4'd4, 4'd4, 2'd0, 4'd0,  1'b0, 4'd5}, // R5 scale, masked bits
    '{16'hF200, 16'h5C1A, 4'd3, 4'd4, 2'd0, 4'd0,  1'b0, 4'd5}, // R5 fmt 7 pattern is const
    '{16'hF200, 16'h0422, 4'd5, 4'd4, 2'd0, 4'd0,  1'b0, 4'd6}, // R6 register source
    '{16'hF200, 16'h41A3, 4'd5, 4'd4, 2'd0, 4'd4,  1'b0, 4'd7}, // R7 long
    '{16'hF200, 16'h4784, 4'd5, 4'd4, 2'd0, 4'd4,  1'b0, 4'd7}, // R7 single
    '{16'hF200, 16'h48B8, 4'd5, 4'd4, 2'd0, 4'd12, 1'b0, 4'd7}, // R7 extended
    '{16'hF200, 16'h4D00, 4'd5, 4'd4, 2'd0, 4'd0,  1'b1, 4'd7}, // R7 packed unsupported
    '{16'hF200, 16'h5298, 4'd5, 4'd4, 2'd0, 4'd2,  1'b0, 4'd7}, // R7 word
    '{16'hF200, 16'h5720, 4'd5, 4'd4, 2'd0, 4'd8,  1'b0, 4'd7}, // R7 double
    '{16'hF200, 16'h5A3A, 4'd5, 4'd4, 2'd0, 4'd1,  1'b0, 4'd7}, // R7 byte
    '{16'hF280, 16'h1234, 4'd6, 4'd4, 2'd0, 4'd0,  1'b0, 4'd4}, // R4 short branch
    '{16'hF2C0, 16'hFFFF, 4'd6, 4'd6, 2'd0, 4'd0,  1'b0, 4'd4}, // R4 long branch
    '{16'hF248, 16'h0001, 4'd7, 4'd6, 2'd2, 4'd0,  1'b0, 4'd8}, // R8 decrement-branch
    '{16'hF27A, 16'h0002, 4'd7, 4'd6, 2'd3, 4'd0,  1'b0, 4'd8}, // R8 trap word operand
    '{16'hF27B, 16'h0003, 4'd7, 4'd8, 2'd3, 4'd0,  1'b0, 4'd8}, // R8 trap long operand
    '{16'hF27C, 16'h0004, 4'd7, 4'd4, 2'd3, 4'd0,  1'b0, 4'd8}, // R8 trap no operand
    '{16'hF27D, 16'h0005, 4'd8, 4'd0, 2'd0, 4'd0,  1'b0, 4'd8}, // R8 mode 5 illegal
    '{16'hF27F, 16'h0000, 4'd8, 4'd0, 2'd0, 4'd0,  1'b0, 4'd8}, // R8 mode 7 illegal
    '{16'hF278, 16'h0000, 4'd7, 4'd4, 2'd1, 4'd0,  1'b0, 4'd8}, // R8 mode 0 is set
    '{16'hF241, 16'h0000, 4'd7, 4'd4, 2'd1, 4'd0,  1'b0, 4'd8}, // R8 set
    '{16'hF250, 16'h0000, 4'd7, 4'd4, 2'd1, 4'd0,  1'b0, 4'd8}, // R8 set
    '{16'hE200, 16'h0422, 4'd8, 4'd0, 2'd0, 4'd0,  1'b0, 4'd2}, // R2 bad nibble
    '{16'h7200, 16'h0000, 4'd8, 4'd0, 2'd0, 4'd0,  1'b0, 4'd2}, // R2 bad nibble
    '{16'hF400, 16'h0422, 4'd8, 4'd0, 2'd0, 4'd0,  1'b0, 4'd3}, // R3 identity 2
    '{16'hF000, 16'h0000, 4'd8, 4'd0, 2'd0, 4'd0,  1'b0, 4'd3}, // R3 identity 0
    '{16'hF300, 16'h0000, 4'd8, 4'd0, 2'd0, 4'd0,  1'b0, 4'd4}, // R4 type 4
    '{16'hF340, 16'h0000, 4'd8, 4'd0, 2'd0, 4'd0,  1'b0, 4'd4}, // R4 type 5
    '{16'hF380, 16'h0000, 4'd8, 4'd0, 2'd0, 4'd0,  1'b0, 4'd4}, // R4 type 6
    '{16'hF3C0, 16'h0000, 4'd8, 4'd0, 2'd0, 4'd0,  1'b0, 4'd4}, // R4 type 7
    '{16'hF200, 16'h8000, 4'd1, 4'd4, 2'd0, 4'd0,  1'b0, 4'd5}  // R5 control move
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkVec(input vec_t v);
    string tag;
    int expFields;
    tag = $sformatf("R%0d", v.req);
    expFields = (v.cls == 4'd5) ? int'({v.w1[14], v.w1[12:10], v.w1[9:7], v.w1[6:0]}) : 0;
    chk("R1", "outValid", int'(outValid), 1);
    chk(tag, "class", int'(classHot), 1 << v.cls);   // R9 one-hot order
    chk("R9", "illegal", int'(illegal), int'(v.cls == 4'd8));
    chk(tag, "length", int'(lenBytes), int'(v.len));
    chk(tag, "condKind", int'(condKind), int'(v.ck));
    chk("R6", "fields", int'({srcMem, srcFmt, dstReg, opCode}), expFields);
    chk(tag, "srcBytes", int'(srcBytes), int'(v.sz));
    chk(tag, "fmtErr", int'(fmtErr), int'(v.fe));
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    word0 = v.w0; word1 = v.w1; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkVec(v);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "outValid at reset", int'(outValid), 0);
    chk("R10", "classHot at reset", int'(classHot), 0);
    chk("R10", "lenBytes at reset", int'(lenBytes), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outValid idle", int'(outValid), 0);

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R1: outputs hold without a strobe while inputs change
    apply(VECS[20]);
    word0 = 16'hF200; word1 = 16'h5720;
    repeat (3) @(negedge clk);
    chk("R1", "outValid after pulse", int'(outValid), 0);
    chk("R1", "class held", int'(classHot), 1 << 7);
    chk("R1", "length held", int'(lenBytes), 8);
    chk("R1", "srcBytes held", int'(srcBytes), 0);

    // R1: back-to-back strobes
    @(negedge clk);
    word0 = 16'hF2C0; word1 = 16'h0000; inValid = 1'b1;
    @(negedge clk);
    chk("R4", "first of pair length", int'(lenBytes), 6);
    word0 = 16'hF200; word1 = 16'h5A3A;
    @(negedge clk);
    inValid = 1'b0;
    chk("R1", "second of pair valid", int'(outValid), 1);
    chk("R7", "second of pair size", int'(srcBytes), 1);
    @(negedge clk);
    chk("R1", "pulse ends", int'(outValid), 0);

    // R10: reset mid-run clears the result
    apply(VECS[12]);
    rst_n = 1'b0;
    #1;
    chk("R10", "fmtErr cleared", int'(fmtErr), 0);
    chk("R10", "class cleared", int'(classHot), 0);
    chk("R10", "valid cleared", int'(outValid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(VECS[0]);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule